// File: doc/BRIEF.md
# Four-Button Combination Lock

This block opens a lock when four push buttons are pressed in one fixed order. Each raw button level comes straight from a switch and may change at any time relative to the clock. It may also stay high for thousands of cycles. A per-button conditioning stage captures the level on the falling clock edge. It then emits a single one-cycle pulse for each press, and arms again only after it has seen the button released.

A sequence matcher watches the four pulse lines on the rising edge. It counts how far into the secret code the user has got. When the whole code has been entered, it raises `unlock`. The default code is button 4, then 2, then 1, then 3. The match count is brought out as a debug vector so the progress can be observed from outside.

Top module: `combo_lock`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the block returns to idle. After that edge `unlock` is 0 and `dbg_progress` is 0.
- R2: Button k (k = 1..4) is wired to `btn_raw[k-1]`. A press held for any number of cycles counts as exactly one push, and its pulse is never two cycles wide.
- R3: The conditioning stage arms again only after it samples the button low. Press, release and press again counts as two pushes.
- R4: Pressing 4, 2, 1, 3, one button at a time, raises `unlock`. `dbg_progress` gives the number of code presses matched so far, from 0 to 4, and reads 4 exactly when `unlock` is 1.
- R5: Suppose the raw level of the final code button is high at a falling edge. `unlock` then stays 0 after the next rising edge and is 1 after the rising edge after that.
- R6: A single push that is not the next expected button sets progress to 0. The exception is button 4, the first code button, which sets progress to 1.
- R7: A cycle in which more than one button pulses counts as a wrong entry and sets progress to 0, even if one of those buttons is button 4.
- R8: Once open, `unlock` stays high while no button is pushed. The next push clears `unlock` and is matched from idle, so button 4 gives progress 1 and any other button gives 0.
- R9: A reset in the middle of a partial sequence discards it, and the full code is then needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; buttons are sampled on its falling edge, state advances on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| btn_raw | input | 4 | Raw button levels, bit k-1 is button k, high while pressed |
| unlock | output | 1 | High while the lock is open |
| dbg_progress | output | 3 | Number of code presses matched so far |

## Verification
The bound checker watches the internal pulse lines and the progress on every cycle. It checks that no pulse is ever two cycles wide, that progress moves only in a cycle after a pulse, and that a multi-button cycle lands at zero. It also checks that `unlock` rises only from the second-to-last step and falls on the next push. The exact meaning of the code can only be shown by the bench's scenarios. These cover every one of the 256 four-press orders from idle, held presses of thousands of cycles, re-press after release, simultaneous presses, the cycle at which `unlock` rises, and a reset partway through a sequence.

// File: rtl/combo_lock_pkg.sv
// Shared sizes and the default code for the combination lock.
// Assumes button numbers 1..N map to indices 0..N-1.
package combo_lock_pkg;
    localparam int BTN_COUNT = 4;
    localparam int SEQ_LEN   = 4;
    localparam int IDX_W     = $clog2(BTN_COUNT);
    localparam int PROG_W    = $clog2(SEQ_LEN + 1);

    typedef logic [IDX_W-1:0] btn_idx_t;

    // Element 0 is the first press: buttons 4, 2, 1, 3 -> indices 3, 1, 0, 2
    localparam btn_idx_t [SEQ_LEN-1:0] DEFAULT_CODE = {2'd2, 2'd0, 2'd1, 2'd3};
endpackage

// File: rtl/btn_pulse.sv
// Conditions one raw button: captures it on the falling clock edge and
// emits one rising-edge-aligned pulse per press, one cycle wide.
// Assumes the raw level may change at any time; re-arms after a low sample.
module btn_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic pulse
);
    logic smp;
    logic held;

    // Capture the asynchronous level half a cycle before the state edge
    always_ff @(negedge clk) begin
        if (!rst_n) smp <= 1'b0;
        else        smp <= raw;
    end

    // Fire once on a fresh press, remember the press until released
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse <= 1'b0;
            held  <= 1'b0;
        end else begin
            pulse <= smp & ~held;
            held  <= smp;
        end
    end
endmodule

// File: rtl/seq_matcher.sv
// Tracks progress through the button code from one-cycle pulses.
// Assumes pulses are at most one cycle wide per press; more than one
// pulse in a cycle is a wrong entry.
module seq_matcher
    import combo_lock_pkg::*;
#(
    parameter int                      N_BTN = BTN_COUNT,
    parameter int                      LEN   = SEQ_LEN,
    parameter btn_idx_t [LEN-1:0]      CODE  = DEFAULT_CODE,
    localparam int                     PW    = $clog2(LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_BTN-1:0] pulse,
    output logic [PW-1:0]    progress,
    output logic             open_o
);
    logic [PW-1:0] prog_q, prog_d, base;
    btn_idx_t      hit_idx;
    int unsigned   hits;

    // Locate the pulsing button and count simultaneous pulses
    always_comb begin
        hit_idx = '0;
        hits    = $countones(pulse);
        for (int i = 0; i < N_BTN; i++) begin
            if (pulse[i]) hit_idx = btn_idx_t'(i);
        end
    end

    // Next progress: advance on the expected button, otherwise restart
    always_comb begin
        base   = (prog_q == PW'(LEN)) ? '0 : prog_q;
        prog_d = prog_q;
        if (hits > 1) begin
            prog_d = '0;
        end else if (hits == 1) begin
            if (hit_idx == CODE[base])      prog_d = PW'(base + 1'b1);
            else if (hit_idx == CODE[0])    prog_d = PW'(1);
            else                            prog_d = '0;
        end
    end

    // Progress register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) prog_q <= '0;
        else        prog_q <= prog_d;
    end

    assign progress = prog_q;
    assign open_o   = (prog_q == PW'(LEN));
endmodule

// File: rtl/combo_lock.sv
// Four-button combination lock: one conditioning stage per button feeding
// a sequence matcher. Assumes raw buttons are high while pressed.
module combo_lock
    import combo_lock_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [BTN_COUNT-1:0] btn_raw,
    output logic                 unlock,
    output logic [PROG_W-1:0]    dbg_progress
);
    logic [BTN_COUNT-1:0] btn_pulse_v;

    // One conditioning stage per button
    for (genvar b = 0; b < BTN_COUNT; b++) begin : g_btn
        btn_pulse u_pulse (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (btn_raw[b]),
            .pulse (btn_pulse_v[b])
        );
    end

    seq_matcher #(
        .N_BTN (BTN_COUNT),
        .LEN   (SEQ_LEN),
        .CODE  (DEFAULT_CODE)
    ) u_match (
        .clk      (clk),
        .rst_n    (rst_n),
        .pulse    (btn_pulse_v),
        .progress (dbg_progress),
        .open_o   (unlock)
    );
endmodule

// File: rtl/combo_lock_chk.sv
// Cycle checks on the lock, bound to the top module.
module combo_lock_chk
    import combo_lock_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [BTN_COUNT-1:0] pulse,
    input logic [PROG_W-1:0]    progress,
    input logic                 unlock
);
    // R2
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse & $past(pulse)) == '0);

    // R4
    progress_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        progress <= PROG_W'(SEQ_LEN));

    // R6
    progress_moves_on_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (progress != $past(progress)) |-> ($past(pulse) != '0));

    // R7
    multi_press_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(pulse) > 1) |=> (progress == '0));

    // R4
    unlock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(unlock) |-> ($past(progress) == PROG_W'(SEQ_LEN - 1)));

    // R8
    unlock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (unlock && pulse != '0) |=> !unlock);
endmodule

bind combo_lock combo_lock_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .pulse    (btn_pulse_v),
    .progress (dbg_progress),
    .unlock   (unlock)
);

// File: tb/combo_lock_tb_top.sv
module combo_lock_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] btn = 4'b0;
    logic       unlock;
    logic [2:0] dbg_progress;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int code_seq [4] = '{4, 2, 1, 3};

    always #5 clk = ~clk;

    combo_lock dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .btn_raw      (btn),
        .unlock       (unlock),
        .dbg_progress (dbg_progress)
    );

    function automatic int model_next(int prog, int b);
        int base = (prog == 4) ? 0 : prog;
        if (b == code_seq[base]) return base + 1;
        if (b == code_seq[0])    return 1;
        return 0;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #2 rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
    endtask

    // Press with mask for hold cycles, release, settle
    task automatic press_mask(logic [3:0] m, int hold);
        @(posedge clk); #2 btn = m;
        repeat (hold) @(posedge clk);
        #2 btn = 4'b0;
        repeat (3) @(posedge clk);
        #2;
    endtask

    task automatic press(int b, int hold);
        press_mask(4'b1 << (b - 1), hold);
    endtask

    task automatic enter_code();
        for (int i = 0; i < 4; i++) press(code_seq[i], 2);
    endtask

    initial begin
        #2000000;
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        #1;
        check("R1 unlock after reset", unlock, 0);
        check("R1 progress after reset", dbg_progress, 0);

        // R4 R6: sweep all 256 four-press orders from idle
        for (int s = 0; s < 256; s++) begin
            int prog = 0;
            do_reset();
            for (int k = 0; k < 4; k++) begin
                int b = ((s >> (2 * k)) & 3) + 1;
                press(b, 2);
                prog = model_next(prog, b);
                check("R6 sweep progress", dbg_progress, prog);
                check("R4 sweep unlock", unlock, (prog == 4) ? 1 : 0);
            end
        end

        // R2: long held presses count once
        do_reset();
        press(4, 3000);
        check("R2 held 4", dbg_progress, 1);
        press(2, 2500);
        press(1, 2);
        press(3, 4000);
        check("R2 held presses open", unlock, 1);

        // R3: release then press again counts twice (4,2,2 -> 0)
        do_reset();
        press(4, 2); press(2, 2); press(2, 2);
        check("R3 re-press counted", dbg_progress, 0);

        // R5: exact cycle of unlock
        do_reset();
        press(4, 2); press(2, 2); press(1, 2);
        @(posedge clk); #2 btn = 4'b0100;
        @(posedge clk); #2;
        check("R5 unlock one edge later", unlock, 0);
        @(posedge clk); #2;
        check("R5 unlock two edges later", unlock, 1);
        btn = 4'b0;
        repeat (3) @(posedge clk);

        // R8: unlock holds, next push restarts matching
        repeat (50) @(posedge clk);
        #2;
        check("R8 unlock holds", unlock, 1);
        press(4, 2);
        check("R8 restart with 4 unlock", unlock, 0);
        check("R8 restart with 4 progress", dbg_progress, 1);
        press(2, 2); press(1, 2); press(3, 2);
        check("R8 reopen", unlock, 1);
        press(1, 2);
        check("R8 restart with other", dbg_progress, 0);

        // R7: simultaneous presses are wrong, even with button 4
        do_reset();
        press(4, 2);
        press_mask(4'b0011, 2);
        check("R7 two buttons", dbg_progress, 0);
        press_mask(4'b1001, 2);
        check("R7 includes button 4", dbg_progress, 0);
        enter_code();
        check("R7 code after multi", unlock, 1);

        // R9: reset mid-sequence discards progress
        do_reset();
        press(4, 2); press(2, 2); press(1, 2);
        do_reset();
        #1;
        check("R9 reset clears", dbg_progress, 0);
        press(3, 2);
        check("R9 partial not kept", unlock, 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule